// File: doc/BRIEF.md
# USB Start-of-Frame Frame Number Tracker

This block sits behind a USB receive path whose line decoding, bit unstuffing and clock recovery are already done. It watches the stream of packet bytes, picks out Start-of-Frame packets and checks the 5-bit token CRC that guards their 11-bit frame number. It keeps the last frame number that arrived intact. It also keeps two flags that say whether the most recent Start-of-Frame was intact or damaged.

A one-cycle interrupt pulse is raised as soon as the Start-of-Frame packet identifier is seen. The pulse does not wait for the payload or the CRC result, so software or downstream timers can align to the frame boundary with minimum latency. The CRC verdict follows later, when the packet closes. A damaged packet never overwrites the stored frame number. The flags are replaced on every Start-of-Frame and never accumulate.

Top module: `sof_frame_tracker`

## Requirements
- R1: After reset, frame_num, crc_good, crc_bad, sof_pulse and status_byte are all zero.
- R2: A valid byte flagged with in_sop whose value is 0xA5 makes sof_pulse high for exactly the following cycle. This happens before any payload byte or CRC result.
- R3: A packet whose first byte is anything other than 0xA5, including bytes whose upper nibble is not the complement of the lower nibble, produces no pulse and leaves frame_num, crc_good and crc_bad unchanged. Bytes and in_eop strobes outside a Start-of-Frame packet are also ignored.
- R4: A Start-of-Frame packet with exactly two payload bytes and a correct CRC updates frame_num on the clock edge that samples in_eop, so the new value is visible in the following cycle. The first byte supplies frame bits 7..0. Bits 2..0 of the second byte supply frame bits 10..8. On the same edge crc_good becomes 1 and crc_bad becomes 0. in_eop may come with the last byte or on its own in a later cycle.
- R5: Treat the two payload bytes as a 16-bit word, first byte in the low half. Bit 11+i of this word must equal the complement of bit 4-i of the remainder of polynomial x^5+x^2+1, computed bit-serially from seed 5'b11111 over word bits 0 to 10 in ascending order.
- R6: A Start-of-Frame packet with two payload bytes and a wrong CRC sets crc_bad to 1 and crc_good to 0, and frame_num keeps its previous value.
- R7: A Start-of-Frame packet that closes with a payload count other than two is treated as damaged. The flags and frame_num then behave as in R6.
- R8: A new in_sop byte that arrives before a Start-of-Frame packet has closed marks that packet as damaged, as in R6. The new packet is then handled normally, including a new pulse if its identifier is 0xA5.
- R9: crc_good and crc_bad are never both 1. Each closed or aborted Start-of-Frame replaces both flags, so a good packet after a bad one clears crc_bad.
- R10: status_byte is {2'b00, crc_good, crc_bad, 1'b0, frame_num[10:8]}.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | in_data carries a packet byte this cycle |
| in_data | input | 8 | Decoded packet byte |
| in_sop | input | 1 | With in_valid: this byte is a packet identifier |
| in_eop | input | 1 | Packet ends; any byte valid this cycle belongs to it |
| frame_num | output | 11 | Last frame number received intact |
| crc_good | output | 1 | Most recent Start-of-Frame was intact |
| crc_bad | output | 1 | Most recent Start-of-Frame was damaged |
| sof_pulse | output | 1 | One-cycle pulse after a Start-of-Frame identifier |
| status_byte | output | 8 | Packed view of the flags and frame bits 10..8 |

## Verification
The bench sends every one of the 2048 frame numbers with a correct CRC, so a CRC with the wrong seed, polynomial or bit order fails almost every frame. It flips each of the 16 payload bits over many frames; a design that stores the frame before the check would show the corrupted value, and a weak check would pass a flipped bit. It sends every other identifier byte followed by a well-formed payload; a design that decodes loosely would pulse or update here. It also sends short, long and aborted packets; a design that only checks the CRC, or that drops the abort, would leave crc_good set after such packets.

// File: rtl/sof_frame_tracker.sv
module sof_frame_tracker #(
  parameter logic [7:0] SOF_PID = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_sop,
  input  logic        in_eop,
  output logic [10:0] frame_num,
  output logic        crc_good,
  output logic        crc_bad,
  output logic        sof_pulse,
  output logic [7:0]  status_byte
);

  localparam int          WORD_W  = 16;
  localparam logic [4:0]  SEED    = 5'b11111;
  localparam logic [4:0]  POLY    = 5'b00101;
  localparam logic [4:0]  RESIDUE = 5'b01100;

  logic       active;
  logic [1:0] cnt;
  logic [7:0] pay_lo, pay_hi;

  function automatic logic [4:0] crc_residue(input logic [WORD_W-1:0] w);
    logic [4:0] c;
    logic       fb;
    c = SEED;
    for (int i = 0; i < WORD_W; i++) begin
      fb = c[4] ^ w[i];
      c  = {c[3:0], 1'b0} ^ (fb ? POLY : 5'b0);
    end
    return c;
  endfunction

  wire new_pkt  = in_valid && in_sop;
  wire take     = active && in_valid && !in_sop;
  wire aborting = active && new_pkt;
  wire closing  = active && in_eop && !new_pkt;

  wire [1:0] cnt_n   = (take && cnt != 2'd3) ? cnt + 2'd1 : cnt;
  wire [7:0] lo_n    = (take && cnt == 2'd0) ? in_data : pay_lo;
  wire [7:0] hi_n    = (take && cnt == 2'd1) ? in_data : pay_hi;
  wire       intact  = (cnt_n == 2'd2) && (crc_residue({hi_n, lo_n}) == RESIDUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cnt       <= 2'd0;
      pay_lo    <= 8'h00;
      pay_hi    <= 8'h00;
      frame_num <= '0;
      crc_good  <= 1'b0;
      crc_bad   <= 1'b0;
      sof_pulse <= 1'b0;
    end else begin
      sof_pulse <= new_pkt && (in_data == SOF_PID);
      if (new_pkt) begin
        if (aborting) begin
          crc_good <= 1'b0;
          crc_bad  <= 1'b1;
        end
        active <= (in_data == SOF_PID);
        cnt    <= 2'd0;
      end else if (closing) begin
        active   <= 1'b0;
        crc_good <= intact;
        crc_bad  <= !intact;
        if (intact) frame_num <= {hi_n[2:0], lo_n};
      end else if (take) begin
        cnt    <= cnt_n;
        pay_lo <= lo_n;
        pay_hi <= hi_n;
      end
    end
  end

  assign status_byte = {2'b00, crc_good, crc_bad, 1'b0, frame_num[10:8]};

  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(crc_good && crc_bad));

  a_r2_pulse_follows_pid: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |-> $past(in_valid && in_sop && in_data == SOF_PID));

  a_r6_frame_moves_only_when_good: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_num) |-> crc_good);

  a_r8_bad_needs_close_or_abort: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_bad) |-> $past(in_eop || (in_valid && in_sop)));

  a_r3_quiet_without_packet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid || in_eop) |-> ($stable(frame_num) && $stable(crc_good) && !sof_pulse));

endmodule

// File: tb/sof_frame_tracker_bench.sv
module sof_frame_tracker_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [7:0]  in_data = 0;
  logic        in_sop = 0;
  logic        in_eop = 0;
  logic [10:0] frame_num;
  logic        crc_good, crc_bad, sof_pulse;
  logic [7:0]  status_byte;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [10:0] last_good = 0;

  always #2.5 clk = ~clk;

  sof_frame_tracker u_sof_frame_tracker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .frame_num(frame_num),
    .crc_good(crc_good), .crc_bad(crc_bad), .sof_pulse(sof_pulse),
    .status_byte(status_byte));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input bit v, input logic [7:0] d, input bit s, input bit e);
    in_valid = v; in_data = d; in_sop = s; in_eop = e;
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  // Payload word: frame in bits 10..0, bit 11+i = ~remainder[4-i]
  function automatic logic [15:0] sof_word(input logic [10:0] f);
    logic [4:0] r;
    logic [15:0] w;
    r = 5'h1F;
    for (int i = 0; i < 11; i++)
      r = r[4] != f[i] ? ((r << 1) ^ 5'h05) : (r << 1);
    w = {5'b0, f};
    for (int i = 0; i < 5; i++) w[11+i] = ~r[4-i];
    return w;
  endfunction

  task automatic expect_state(input string req, input bit g);
    chk({req, " frame"}, frame_num, last_good);
    chk({req, " good"}, crc_good, g);
    chk({req, " bad"}, crc_bad, !g);
    chk("R9 exclusive", crc_good & crc_bad, 0);
    chk("R10 status", status_byte, {2'b00, g, !g, 1'b0, last_good[10:8]});
  endtask

  task automatic send_sof(input logic [15:0] w, input bit eop_alone, input bit good);
    put(1, 8'hA5, 1, 0);
    chk("R2 pulse", sof_pulse, 1);
    put(1, w[7:0], 0, 0);
    chk("R2 single", sof_pulse, 0);
    if (eop_alone) begin
      put(1, w[15:8], 0, 0);
      put(0, 8'h00, 0, 1);
    end else put(1, w[15:8], 0, 1);
    if (good) last_good = w[10:0];
    expect_state(good ? "R4" : "R6", good);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 frame", frame_num, 0);
    chk("R1 good", crc_good, 0);
    chk("R1 bad", crc_bad, 0);
    chk("R1 pulse", sof_pulse, 0);
    chk("R1 status", status_byte, 0);
    rst_n = 1;
    @(negedge clk);

    // R4 R5 all frame numbers with correct CRC
    for (int f = 0; f < 2048; f++) send_sof(sof_word(f[10:0]), f[0], 1);

    // R6 single-bit damage on each payload bit, frame held
    for (int f = 3; f < 2048; f += 97)
      for (int b = 0; b < 16; b++) begin
        send_sof(sof_word(f[10:0]) ^ (16'h1 << b), b[0], 0);
        send_sof(sof_word(f[10:0] ^ 11'h2AA), 0, 1);
      end

    // R7 wrong payload counts
    for (int n = 0; n < 5; n++) begin
      if (n == 2) continue;
      put(1, 8'hA5, 1, 0);
      chk("R2 pulse len", sof_pulse, 1);
      for (int k = 0; k < n; k++) put(1, sof_word(11'h155)[7:0], 0, 0);
      put(0, 8'h00, 0, 1);
      expect_state("R7", 0);
      send_sof(sof_word(11'h0F0), 0, 1);
    end

    // R8 abort by new SOF identifier, then new packet completes
    put(1, 8'hA5, 1, 0);
    put(1, 8'h12, 0, 0);
    put(1, 8'hA5, 1, 0);
    chk("R8 new pulse", sof_pulse, 1);
    expect_state("R8 abort", 0);
    put(1, sof_word(11'h7FE)[7:0], 0, 0);
    put(1, sof_word(11'h7FE)[15:8], 0, 1);
    last_good = 11'h7FE;
    expect_state("R8 resume", 1);
    // R8 abort by other identifier
    put(1, 8'hA5, 1, 0);
    put(1, 8'hE1, 1, 0);
    chk("R8 no pulse", sof_pulse, 0);
    expect_state("R8 abort2", 0);
    put(0, 8'h00, 0, 1);
    expect_state("R8 stray eop", 0);
    send_sof(sof_word(11'h321), 1, 1);

    // R3 every other identifier ignored
    for (int p = 0; p < 256; p++) begin
      if (p == 8'hA5) continue;
      put(1, p[7:0], 1, 0);
      chk("R3 pulse", sof_pulse, 0);
      put(1, sof_word(11'h04C)[7:0], 0, 0);
      put(1, sof_word(11'h04C)[15:8], 0, 1);
      expect_state("R3", 1);
    end
    send_sof(sof_word(11'h400) ^ 16'h8000, 0, 0);
    put(1, 8'h2D, 1, 0);
    put(0, 8'h00, 0, 1);
    expect_state("R3 keep bad", 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule